// File: doc/BRIEF.md
# Microcode Sequencer with Restricted Jump Logic

This block is the control unit of a bus-based, microcoded processor. It keeps a micro-program counter (uPC), reads one word per cycle from a built-in control store and drives the datapath control lines held in that word. Each word also carries a small jump-type code and an absolute target. The next uPC is not stored in full in every word. It is computed from the jump type, the memory busy flag, the zero flag and a dispatch table that turns the macro-opcode into the start address of a routine.

The control store holds these routines: instruction fetch, register ALU, immediate ALU, load, store, jump, jump-and-link, jump-register, jump-and-link-register, and branch-if-zero / branch-if-nonzero with a shared taken path. An opcode that is not in the dispatch table sends the sequencer to a trap state. There it flags an illegal instruction, drives no control line and waits for reset.

Top module: `ucode_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, uPC becomes 0, the first fetch state, and illegal reads 0.
- R2: The fetch routine occupies uPC 0,1,2,3. State 0 always goes to 1. State 1 holds while busy is 1 and moves to 2 when busy is 0. State 2 goes to 3, and state 3 dispatches.
- R3: ctl bit map: [17] load IR, [16:14] register select (0 rs, 1 rt, 2 rd, 3 PC, 4 link), [13] register write, [12] register drive, [11] load A, [10] load B, [9:7] ALU op (1 = A+4), [6] ALU drive, [5] load MA, [4] memory write, [3] memory drive, [2:1] immediate select, [0] immediate drive. The fetch states give state 0: select PC, register drive, load MA. State 1: memory drive, load IR. State 2: select PC, register drive, load A. State 3: select PC, register write, ALU op 1, ALU drive.
- R4: Dispatch from state 3 goes to these uPC addresses. Opcode 0x00 goes to 4. Opcodes 0x08 to 0x0F go to 7. 0x23 goes to 10 and 0x2B to 15. 0x02 goes to 20 and 0x03 to 23. 0x10 goes to 27 and 0x11 to 29. 0x04 goes to 33 and 0x05 to 35.
- R5: Routines run one state per cycle through consecutive addresses and return to uPC 0 after their last state. The last states are: register ALU 6, immediate ALU 9, load 14, store 19, jump 22, jump-and-link 26, jump-register 28, jump-and-link-register 32.
- R6: busy affects only spin states (1, 13, 18). zero affects only the branch test states (33, 35).
- R7: The load spin state 13 and the store spin state 18 hold while busy is 1 and advance by one when busy is 0.
- R8: Branch-if-zero goes from state 33 to 37 when zero is 1, and to 34 and then 0 otherwise. Branch-if-nonzero goes from 35 to 37 when zero is 0, and to 36 and then 0 otherwise. The taken path is 37, 38, 39, then 0.
- R9: Any other opcode dispatches to trap state 40. There illegal is 1 and ctl is all zero, and uPC stays at 40 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Macro-opcode from the instruction register |
| zero | input | 1 | Datapath zero flag |
| busy | input | 1 | Memory busy flag |
| ctl | output | 18 | Datapath control lines of the current microinstruction |
| upc | output | 6 | Current micro-program counter |
| illegal | output | 1 | High while in the trap state |

## Verification
A wrong uPC shows at the upc port and on ctl in the same cycle, because the control store is read combinationally from the uPC register. A wrong jump decision therefore shows one clock edge after the state that made it. A bad dispatch entry shows one cycle after fetch state 3. A spin that ignores busy shows as a uPC that leaves early or holds too long. A trap that is not sticky shows as a uPC change away from 40 before reset.

// File: rtl/ucode_pkg.sv
// Package for the microcode sequencer. It holds the jump-type codes, the control-word
// layout and the micro-addresses of each routine in the control store.
// Assumes a 6-bit macro-opcode and a 64-entry control store.
package ucode_pkg;

    localparam int UPC_W  = 6;
    localparam int OP_W   = 6;
    localparam int ROM_N  = 1 << UPC_W;

    typedef logic [UPC_W-1:0] upc_t;
    typedef logic [OP_W-1:0]  op_t;

    typedef enum logic [2:0] {
        JT_NEXT     = 3'd0,
        JT_SPIN     = 3'd1,
        JT_FETCH    = 3'd2,
        JT_DISPATCH = 3'd3,
        JT_FEQZ     = 3'd4,
        JT_FNEZ     = 3'd5,
        JT_HALT     = 3'd6
    } jtype_t;

    typedef enum logic [2:0] {
        RS_RS = 3'd0, RS_RT = 3'd1, RS_RD = 3'd2, RS_PC = 3'd3, RS_LINK = 3'd4
    } regsel_t;

    typedef enum logic [2:0] {
        AO_PASSA = 3'd0, AO_INC4 = 3'd1, AO_ADD = 3'd2, AO_JTGT = 3'd3,
        AO_FUNC  = 3'd4, AO_OPC  = 3'd5, AO_PASSB = 3'd6
    } aluop_t;

    typedef enum logic [1:0] {
        IM_SEXT = 2'd0, IM_SEXT2 = 2'd1, IM_IR = 2'd2, IM_ZEXT = 2'd3
    } immsel_t;

    typedef struct packed {
        logic    ld_ir;
        regsel_t reg_sel;
        logic    reg_wr;
        logic    en_reg;
        logic    ld_a;
        logic    ld_b;
        aluop_t  alu_op;
        logic    en_alu;
        logic    ld_ma;
        logic    mem_wr;
        logic    en_mem;
        immsel_t imm_sel;
        logic    en_imm;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        ctl_t   ctl;
        jtype_t jt;
        upc_t   tgt;
    } uword_t;

    // Routine addresses in the control store
    localparam upc_t ST_F0    = 6'd0;
    localparam upc_t ST_F1    = 6'd1;
    localparam upc_t ST_F2    = 6'd2;
    localparam upc_t ST_F3    = 6'd3;
    localparam upc_t ST_ALU   = 6'd4;
    localparam upc_t ST_ALUI  = 6'd7;
    localparam upc_t ST_LD    = 6'd10;
    localparam upc_t ST_LDSP  = 6'd13;
    localparam upc_t ST_ST    = 6'd15;
    localparam upc_t ST_STSP  = 6'd18;
    localparam upc_t ST_J     = 6'd20;
    localparam upc_t ST_JL    = 6'd23;
    localparam upc_t ST_JR    = 6'd27;
    localparam upc_t ST_JLR   = 6'd29;
    localparam upc_t ST_BZ    = 6'd33;
    localparam upc_t ST_BN    = 6'd35;
    localparam upc_t ST_TAKEN = 6'd37;
    localparam upc_t ST_TRAP  = 6'd40;

endpackage

// File: rtl/ucode_rom.sv
// Control store: a combinational read of one microinstruction per micro-address.
// The contents are fixed constants. Every address not used by a routine holds the trap word.
module ucode_rom
    import ucode_pkg::*;
(
    input  upc_t   addr,
    output uword_t word
);

    // Register file drives the bus into A or B
    function automatic ctl_t reg_to(input regsel_t s, input logic to_a);
        ctl_t c = '0;
        c.reg_sel = s;
        c.en_reg  = 1'b1;
        c.ld_a    = to_a;
        c.ld_b    = !to_a;
        return c;
    endfunction

    // ALU drives the bus into a register, into MA, or both
    function automatic ctl_t alu_to(input aluop_t op, input regsel_t s, input logic wr, input logic ma);
        ctl_t c = '0;
        c.alu_op  = op;
        c.en_alu  = 1'b1;
        c.reg_sel = s;
        c.reg_wr  = wr;
        c.ld_ma   = ma;
        return c;
    endfunction

    // Immediate extender drives the bus into B
    function automatic ctl_t imm_to_b(input immsel_t m);
        ctl_t c = '0;
        c.imm_sel = m;
        c.en_imm  = 1'b1;
        c.ld_b    = 1'b1;
        return c;
    endfunction

    // Microinstruction decode of the current address
    always_comb begin
        word     = '0;
        word.jt  = JT_NEXT;
        word.tgt = ST_F0;
        case (addr)
            6'd0:  begin word.ctl = reg_to(RS_PC, 1'b1); word.ctl.ld_a = 1'b0; word.ctl.ld_ma = 1'b1; end
            6'd1:  begin word.ctl.en_mem = 1'b1; word.ctl.ld_ir = 1'b1; word.jt = JT_SPIN; end
            6'd2:  word.ctl = reg_to(RS_PC, 1'b1);
            6'd3:  begin word.ctl = alu_to(AO_INC4, RS_PC, 1'b1, 1'b0); word.jt = JT_DISPATCH; end
            6'd4:  word.ctl = reg_to(RS_RS, 1'b1);
            6'd5:  word.ctl = reg_to(RS_RT, 1'b0);
            6'd6:  begin word.ctl = alu_to(AO_FUNC, RS_RD, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd7:  word.ctl = reg_to(RS_RS, 1'b1);
            6'd8:  word.ctl = imm_to_b(IM_SEXT);
            6'd9:  begin word.ctl = alu_to(AO_OPC, RS_RT, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd10: word.ctl = reg_to(RS_RS, 1'b1);
            6'd11: word.ctl = imm_to_b(IM_SEXT);
            6'd12: word.ctl = alu_to(AO_ADD, RS_RS, 1'b0, 1'b1);
            6'd13: begin word.ctl.en_mem = 1'b1; word.ctl.reg_sel = RS_RT; word.ctl.reg_wr = 1'b1; word.jt = JT_SPIN; end
            6'd14: word.jt = JT_FETCH;
            6'd15: word.ctl = reg_to(RS_RS, 1'b1);
            6'd16: word.ctl = imm_to_b(IM_SEXT);
            6'd17: word.ctl = alu_to(AO_ADD, RS_RS, 1'b0, 1'b1);
            6'd18: begin word.ctl.reg_sel = RS_RT; word.ctl.en_reg = 1'b1; word.ctl.mem_wr = 1'b1; word.jt = JT_SPIN; end
            6'd19: word.jt = JT_FETCH;
            6'd20: word.ctl = reg_to(RS_PC, 1'b1);
            6'd21: word.ctl = imm_to_b(IM_IR);
            6'd22: begin word.ctl = alu_to(AO_JTGT, RS_PC, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd23: word.ctl = reg_to(RS_PC, 1'b1);
            6'd24: word.ctl = alu_to(AO_PASSA, RS_LINK, 1'b1, 1'b0);
            6'd25: word.ctl = imm_to_b(IM_IR);
            6'd26: begin word.ctl = alu_to(AO_JTGT, RS_PC, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd27: word.ctl = reg_to(RS_RS, 1'b1);
            6'd28: begin word.ctl = alu_to(AO_PASSA, RS_PC, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd29: word.ctl = reg_to(RS_PC, 1'b1);
            6'd30: word.ctl = reg_to(RS_RS, 1'b0);
            6'd31: word.ctl = alu_to(AO_PASSA, RS_LINK, 1'b1, 1'b0);
            6'd32: begin word.ctl = alu_to(AO_PASSB, RS_PC, 1'b1, 1'b0); word.jt = JT_FETCH; end
            6'd33: begin word.ctl = reg_to(RS_RS, 1'b1); word.jt = JT_FEQZ; word.tgt = ST_TAKEN; end
            6'd34: word.jt = JT_FETCH;
            6'd35: begin word.ctl = reg_to(RS_RS, 1'b1); word.jt = JT_FNEZ; word.tgt = ST_TAKEN; end
            6'd36: word.jt = JT_FETCH;
            6'd37: word.ctl = reg_to(RS_PC, 1'b1);
            6'd38: word.ctl = imm_to_b(IM_SEXT2);
            6'd39: begin word.ctl = alu_to(AO_ADD, RS_PC, 1'b1, 1'b0); word.jt = JT_FETCH; end
            default: begin word.jt = JT_HALT; word.tgt = ST_TRAP; end
        endcase
    end

endmodule

// File: rtl/ucode_dispatch.sv
// Dispatch table: maps a macro-opcode to the start address of its op-group routine.
// Opcodes with no entry map to the trap state.
module ucode_dispatch
    import ucode_pkg::*;
(
    input  op_t  opcode,
    output upc_t start
);

    // Op-group lookup
    always_comb begin
        case (opcode)
            6'h00:   start = ST_ALU;
            6'h08, 6'h09, 6'h0A, 6'h0B,
            6'h0C, 6'h0D, 6'h0E, 6'h0F: start = ST_ALUI;
            6'h23:   start = ST_LD;
            6'h2B:   start = ST_ST;
            6'h02:   start = ST_J;
            6'h03:   start = ST_JL;
            6'h10:   start = ST_JR;
            6'h11:   start = ST_JLR;
            6'h04:   start = ST_BZ;
            6'h05:   start = ST_BN;
            default: start = ST_TRAP;
        endcase
    end

endmodule

// File: rtl/ucode_next.sv
// Jump logic: selects the next micro-address from the jump type of the current word.
// Assumes busy and zero are valid during the cycle of the word that tests them.
module ucode_next
    import ucode_pkg::*;
(
    input  upc_t   upc,
    input  jtype_t jt,
    input  upc_t   tgt,
    input  upc_t   start,
    input  logic   zero,
    input  logic   busy,
    output upc_t   nxt
);

    upc_t inc;
    assign inc = upc + 1'b1;

    // Next-address multiplexer
    always_comb begin
        case (jt)
            JT_NEXT:     nxt = inc;
            JT_SPIN:     nxt = busy ? upc : inc;
            JT_FETCH:    nxt = tgt;
            JT_DISPATCH: nxt = start;
            JT_FEQZ:     nxt = zero ? tgt : inc;
            JT_FNEZ:     nxt = zero ? inc : tgt;
            default:     nxt = upc;
        endcase
    end

endmodule

// File: rtl/ucode_seq.sv
// Microcode sequencer top: the uPC register, the control store read, dispatch and jump logic.
// Control lines follow the uPC combinationally, so each microinstruction takes one cycle.
module ucode_seq
    import ucode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic             zero,
    input  logic             busy,
    output logic [CTL_W-1:0] ctl,
    output logic [UPC_W-1:0] upc,
    output logic             illegal
);

    upc_t   upc_q;
    upc_t   upc_d;
    upc_t   start;
    uword_t word;

    ucode_rom u_rom (
        .addr (upc_q),
        .word (word)
    );

    ucode_dispatch u_disp (
        .opcode (opcode),
        .start  (start)
    );

    ucode_next u_next (
        .upc   (upc_q),
        .jt    (word.jt),
        .tgt   (word.tgt),
        .start (start),
        .zero  (zero),
        .busy  (busy),
        .nxt   (upc_d)
    );

    // uPC register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= ST_F0;
        else        upc_q <= upc_d;
    end

    assign ctl     = word.ctl;
    assign upc     = upc_q;
    assign illegal = (word.jt == JT_HALT);

endmodule

// File: rtl/ucode_seq_chk.sv
// Checker for the sequencer, bound to every instance of ucode_seq.
module ucode_seq_chk
    import ucode_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             zero,
    input logic             busy,
    input logic [CTL_W-1:0] ctl,
    input logic [UPC_W-1:0] upc,
    input logic             illegal
);

    assert_fetch_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upc == ST_F0 |=> upc == ST_F1);

    assert_fetch_spin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ST_F1 && busy) |=> upc == ST_F1);

    assert_load_spin_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ST_LDSP && !busy) |=> upc == ST_LDSP + 6'd1);

    assert_store_spin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ST_STSP && busy) |=> upc == ST_STSP);

    assert_beqz_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ST_BZ && zero) |=> upc == ST_TAKEN);

    assert_bnez_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == ST_BN && zero) |=> upc == ST_BN + 6'd1);

    assert_trap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal && $stable(upc));

    assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ctl == '0);

endmodule

bind ucode_seq ucode_seq_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero    (zero),
    .busy    (busy),
    .ctl     (ctl),
    .upc     (upc),
    .illegal (illegal)
);

// File: tb/test_ucode_seq.sv
// Sweeps every opcode through the sequencer and checks the uPC path, fetch control words,
// spin behaviour on busy, branch decisions on zero and the trap state.
module test_ucode_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic        zero = 1'b0;
    logic        busy = 1'b0;
    logic [17:0] ctl;
    logic [5:0]  upc;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ucode_seq i_ucode_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .zero    (zero),
        .busy    (busy),
        .ctl     (ctl),
        .upc     (upc),
        .illegal (illegal)
    );

    // Expected fetch control words from the R3 bit map
    localparam logic [17:0] C_F0 = (18'd3 << 14) | (18'd1 << 12) | (18'd1 << 5);
    localparam logic [17:0] C_F1 = (18'd1 << 17) | (18'd1 << 3);
    localparam logic [17:0] C_F2 = (18'd3 << 14) | (18'd1 << 12) | (18'd1 << 11);
    localparam logic [17:0] C_F3 = (18'd3 << 14) | (18'd1 << 13) | (18'd1 << 7) | (18'd1 << 6);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Check the state present in this cycle, then move to the next cycle
    task automatic expect_upc(input logic [5:0] exp, input string req);
        #1;
        check(upc === exp, req, upc, exp);
        check(illegal === (exp == 6'd40), {req, " illegal"}, illegal, exp == 6'd40);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(upc === 6'd0, "R1 reset upc", upc, 0);
        check(illegal === 1'b0, "R1 reset illegal", illegal, 0);
        rst_n = 1'b1;
    endtask

    // R4/R5 expected routine by opcode: start, last, spin state (63 = none)
    task automatic group_of(input logic [5:0] op, output int s, output int l, output int sp);
        sp = 63;
        if (op == 6'h00)                       begin s = 4;  l = 6;  end
        else if (op >= 6'h08 && op <= 6'h0F)   begin s = 7;  l = 9;  end
        else if (op == 6'h23)                  begin s = 10; l = 14; sp = 13; end
        else if (op == 6'h2B)                  begin s = 15; l = 19; sp = 18; end
        else if (op == 6'h02)                  begin s = 20; l = 22; end
        else if (op == 6'h03)                  begin s = 23; l = 26; end
        else if (op == 6'h10)                  begin s = 27; l = 28; end
        else if (op == 6'h11)                  begin s = 29; l = 32; end
        else if (op == 6'h04)                  begin s = 33; l = 33; end
        else if (op == 6'h05)                  begin s = 35; l = 35; end
        else                                   begin s = 40; l = 40; end
    endtask

    task automatic run_instr(input logic [5:0] op, input logic z, input int k);
        int s, l, sp;
        group_of(op, s, l, sp);
        opcode = op;
        zero = z;
        busy = 1'b1;
        #1;
        check(ctl === C_F0, "R3 fetch0 ctl", ctl, C_F0);
        expect_upc(6'd0, "R2 fetch0, busy ignored R6");
        for (int i = 0; i < k; i++) begin
            busy = 1'b1;
            #1;
            check(ctl === C_F1, "R3 fetch1 ctl", ctl, C_F1);
            expect_upc(6'd1, "R2 fetch spin hold");
        end
        busy = 1'b0;
        expect_upc(6'd1, "R2 fetch spin exit");
        busy = 1'b1;
        #1;
        check(ctl === C_F2, "R3 fetch2 ctl", ctl, C_F2);
        expect_upc(6'd2, "R2 fetch2");
        #1;
        check(ctl === C_F3, "R3 fetch3 ctl", ctl, C_F3);
        expect_upc(6'd3, "R2 fetch3");
        if (s == 40) begin
            for (int i = 0; i < 4; i++) begin
                busy = i[0];
                zero = i[1];
                #1;
                check(ctl === '0, "R9 trap ctl", ctl, 0);
                expect_upc(6'd40, "R9 trap held");
            end
            do_reset();
        end else if (s == 33 || s == 35) begin
            expect_upc(6'(s), "R4 branch dispatch");
            if ((s == 33) == z) begin
                expect_upc(6'd37, "R8 taken 0");
                expect_upc(6'd38, "R8 taken 1");
                expect_upc(6'd39, "R8 taken 2");
            end else begin
                expect_upc(6'(s + 1), "R8 not taken");
            end
        end else begin
            for (int st = s; st <= l; st++) begin
                if (st == sp) begin
                    for (int i = 0; i < k; i++) begin
                        busy = 1'b1;
                        expect_upc(6'(st), "R7 spin hold");
                    end
                    busy = 1'b0;
                    expect_upc(6'(st), "R7 spin exit");
                    busy = 1'b1;
                end else begin
                    expect_upc(6'(st), st == s ? "R4 dispatch" : "R5 routine step, zero ignored R6");
                end
            end
        end
    endtask

    initial begin
        do_reset();
        for (int op = 0; op < 64; op++) begin
            if (op == 4 || op == 5) begin
                run_instr(6'(op), 1'b0, op % 3);
                run_instr(6'(op), 1'b1, op % 3);
            end else begin
                run_instr(6'(op), op[1], op % 3);
            end
        end
        expect_upc(6'd0, "R5 return to fetch");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule